// File: doc/BRIEF.md
# BCH Page Layout Reorderer

This block moves one flash page at a time between two byte orders. On the flash side, a page is a run of sections: each section holds its data bytes, then its free spare bytes, then a 30-byte ECC field. An optional shorter tail section with its own data and spare sizes comes last. On the host side, the same page is grouped by kind: every data byte first, then every spare byte, then every ECC field. In the host view, each ECC field takes a 32-byte slot, and the two extra bytes of each slot are 0xFF.

A start pulse samples the geometry and the direction. The block then takes the whole page into an internal buffer through a valid/ready byte port. After the last input byte it emits the page in the other order through a second valid/ready port, and it pulses `done` after the last output byte. ECC bytes are moved without being interpreted. If the number of received bytes disagrees with the configured geometry, the block raises an error flag that stays set.

Top module: `bch_page_reorder`

## Requirements
- R1: After reset, `in_ready`, `out_valid`, `done`, `len_err` and `busy` are all low.
- R2: The configuration inputs are sampled only when `start` is high while the block is idle. Changes to them during a page have no effect on that page.
- R3: With `cfg_to_ctrl`=0 (flash order in, host order out), the output holds all data bytes in section order, then all spare bytes in section order, then the ECC slots in section order.
- R4: In the host view, each 30-byte ECC field is followed by two 0xFF bytes, so that slot k starts at offset 32*k within the ECC region.
- R5: With `cfg_to_ctrl`=1 (host order in, flash order out), the output is, per section, its data, then its spare, then its 30 ECC bytes. The two pad bytes of each input slot are dropped, whatever their value.
- R6: When `cfg_tail_en`=1, one extra section with sizes `cfg_tail_data_len`/`cfg_tail_spare_len` follows the `cfg_sections` full sections, in both layouts.
- R7: A spare size of zero is legal. Such a section goes from data straight to ECC.
- R8: `out_valid` stays low until the input byte marked `in_last` has been accepted. `in_ready` and `out_valid` are never high together.
- R9: `done` is high for exactly one cycle, in the cycle after the last output handshake. While `out_valid` is high and `out_ready` is low, `out_byte` holds its value.
- R10: If the byte carrying `in_last` is not the byte at position (expected page length − 1), `len_err` is set and stays set until reset. The full configured output length is still emitted.
- R11: Data sizes from 512 up to 2048 bytes per section are handled, as long as the host-view page fits the buffer (`BUF_DEPTH` bytes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a page and samples the configuration when the block is idle |
| cfg_to_ctrl | input | 1 | 0: flash order to host order, 1: host order to flash order |
| cfg_sections | input | SECT_W | Number of full sections |
| cfg_data_len | input | LEN_W | Data bytes per full section (at least 1) |
| cfg_spare_len | input | SPR_W | Spare bytes per full section |
| cfg_tail_en | input | 1 | Adds the tail section |
| cfg_tail_data_len | input | LEN_W | Data bytes of the tail section (at least 1) |
| cfg_tail_spare_len | input | SPR_W | Spare bytes of the tail section |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts input (capture phase) |
| in_byte | input | 8 | Input byte |
| in_last | input | 1 | Marks the final input byte of the page |
| out_valid | output | 1 | Output byte valid (emission phase) |
| out_ready | input | 1 | Downstream accepts output |
| out_byte | output | 8 | Output byte |
| done | output | 1 | One-cycle pulse after the last output byte |
| len_err | output | 1 | Sticky page-length mismatch flag |
| busy | output | 1 | A page is in progress |

## Verification
A section walker that goes wrong misplaces a byte in its very first segment change. In a flash-to-host page, the first spare or ECC byte then lands at a wrong offset, and the first byte emitted after the data region is wrong. A pad position that is off shows up as a non-0xFF byte at the end of the first ECC slot, or as a missing or extra byte in the host-to-flash output count, so `done` comes early or late. A bad phase state shows at once as `out_valid` during capture or a `done` pulse longer than one cycle. A bad length check shows in `len_err` on the cycle after the `in_last` byte.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
  localparam int ECC_LEN  = 30;
  localparam int ECC_SLOT = 32;

  typedef enum logic [1:0] {
    SEG_DATA  = 2'd0,
    SEG_SPARE = 2'd1,
    SEG_ECC   = 2'd2
  } seg_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FILL  = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;
endpackage

// File: rtl/bpr_geom.sv
module bpr_geom #(
  parameter int SECT_W = 4,
  parameter int LEN_W  = 12,
  parameter int SPR_W  = 8,
  parameter int CNT_W  = 18
) (
  input  logic [SECT_W-1:0] ns,
  input  logic [LEN_W-1:0]  dl,
  input  logic [SPR_W-1:0]  sl,
  input  logic              ten,
  input  logic [LEN_W-1:0]  tdl,
  input  logic [SPR_W-1:0]  tsl,
  output logic [CNT_W-1:0]  dtot,
  output logic [CNT_W-1:0]  stot,
  output logic [CNT_W-1:0]  ctrl_len,
  output logic [CNT_W-1:0]  user_len
);
  import bpr_pkg::*;

  logic [CNT_W-1:0] nt;

  always_comb begin
    nt   = CNT_W'(ns) + CNT_W'(ten);
    dtot = CNT_W'(ns) * CNT_W'(dl) + (ten ? CNT_W'(tdl) : '0);
    stot = CNT_W'(ns) * CNT_W'(sl) + (ten ? CNT_W'(tsl) : '0);
    ctrl_len = dtot + stot + nt * CNT_W'(ECC_LEN);
    user_len = dtot + stot + nt * CNT_W'(ECC_SLOT);
  end
endmodule

// File: rtl/bpr_walk.sv
module bpr_walk #(
  parameter int SECT_W = 4,
  parameter int LEN_W  = 12,
  parameter int SPR_W  = 8,
  parameter int CNT_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              step,
  input  logic [SECT_W-1:0] ns,
  input  logic [LEN_W-1:0]  dl,
  input  logic [SPR_W-1:0]  sl,
  input  logic [LEN_W-1:0]  tdl,
  input  logic [SPR_W-1:0]  tsl,
  input  logic [CNT_W-1:0]  sbase,
  input  logic [CNT_W-1:0]  ebase,
  output logic [CNT_W-1:0]  addr
);
  import bpr_pkg::*;

  seg_e              seg_q, seg_d;
  logic [LEN_W-1:0]  off_q, off_d;
  logic [SECT_W-1:0] sect_q, sect_d;
  logic [CNT_W-1:0]  dptr_q, dptr_d, sptr_q, sptr_d, eptr_q, eptr_d;
  logic              in_tail, seg_end;
  logic [SPR_W-1:0]  cur_spare;
  logic [LEN_W-1:0]  seg_len;

  // Segment geometry of the section under the walker
  always_comb begin
    in_tail   = (sect_q == ns);
    cur_spare = in_tail ? tsl : sl;
    case (seg_q)
      SEG_DATA:  seg_len = in_tail ? tdl : dl;
      SEG_SPARE: seg_len = LEN_W'(cur_spare);
      default:   seg_len = LEN_W'(ECC_LEN);
    endcase
    seg_end = (off_q == seg_len - LEN_W'(1));
  end

  // Host-view address of the current flash-order byte
  always_comb begin
    case (seg_q)
      SEG_DATA:  addr = dptr_q;
      SEG_SPARE: addr = sbase + sptr_q;
      default:   addr = ebase + eptr_q;
    endcase
  end

  always_comb begin
    seg_d  = seg_q;
    off_d  = off_q;
    sect_d = sect_q;
    dptr_d = dptr_q;
    sptr_d = sptr_q;
    eptr_d = eptr_q;
    if (init) begin
      seg_d  = SEG_DATA;
      off_d  = '0;
      sect_d = '0;
      dptr_d = '0;
      sptr_d = '0;
      eptr_d = '0;
    end else if (step) begin
      case (seg_q)
        SEG_DATA:  dptr_d = dptr_q + CNT_W'(1);
        SEG_SPARE: sptr_d = sptr_q + CNT_W'(1);
        default:   eptr_d = eptr_q + (seg_end ? CNT_W'(ECC_SLOT - ECC_LEN + 1) : CNT_W'(1));
      endcase
      if (seg_end) begin
        off_d = '0;
        case (seg_q)
          SEG_DATA:  seg_d = (cur_spare == '0) ? SEG_ECC : SEG_SPARE;
          SEG_SPARE: seg_d = SEG_ECC;
          default: begin
            seg_d  = SEG_DATA;
            sect_d = sect_q + SECT_W'(1);
          end
        endcase
      end else begin
        off_d = off_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_DATA;
      off_q  <= '0;
      sect_q <= '0;
      dptr_q <= '0;
      sptr_q <= '0;
      eptr_q <= '0;
    end else if (init || step) begin
      seg_q  <= seg_d;
      off_q  <= off_d;
      sect_q <= sect_d;
      dptr_q <= dptr_d;
      sptr_q <= sptr_d;
      eptr_q <= eptr_d;
    end
  end
endmodule

// File: rtl/bpr_buf.sv
module bpr_buf #(
  parameter int DEPTH = 4096,
  parameter int AW_IN = 18
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW_IN-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [AW_IN-1:0] raddr,
  output logic [7:0]       rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];
  logic       w_in, r_in;

  always_comb begin
    w_in  = (waddr < AW_IN'(DEPTH));
    r_in  = (raddr < AW_IN'(DEPTH));
    rdata = r_in ? mem[raddr[AW-1:0]] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we && w_in) mem[waddr[AW-1:0]] <= wdata;
  end
endmodule

// File: rtl/bch_page_reorder.sv
module bch_page_reorder
  import bpr_pkg::*;
#(
  parameter int SECT_W    = 4,
  parameter int LEN_W     = 12,
  parameter int SPR_W     = 8,
  parameter int BUF_DEPTH = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_to_ctrl,
  input  logic [SECT_W-1:0] cfg_sections,
  input  logic [LEN_W-1:0]  cfg_data_len,
  input  logic [SPR_W-1:0]  cfg_spare_len,
  input  logic              cfg_tail_en,
  input  logic [LEN_W-1:0]  cfg_tail_data_len,
  input  logic [SPR_W-1:0]  cfg_tail_spare_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              done,
  output logic              len_err,
  output logic              busy
);
  localparam int CNT_W = SECT_W + LEN_W + 2;

  phase_e            ph_q, ph_d;
  logic              to_ctrl_q, ten_q;
  logic [SECT_W-1:0] ns_q;
  logic [LEN_W-1:0]  dl_q, tdl_q;
  logic [SPR_W-1:0]  sl_q, tsl_q;
  logic [CNT_W-1:0]  in_cnt_q, in_cnt_d, out_cnt_q, out_cnt_d;
  logic              done_q, done_d, err_q, err_d;
  logic [CNT_W-1:0]  dtot, stot, ctrl_len, user_len, ecc_base;
  logic [CNT_W-1:0]  exp_in, out_len, walk_addr, wr_addr, rd_addr;
  logic              go, in_fire, out_fire, wr_en, walk_step, pad_hit;
  logic [7:0]        rd_data;

  bpr_geom #(.SECT_W(SECT_W), .LEN_W(LEN_W), .SPR_W(SPR_W), .CNT_W(CNT_W)) u_geom (
    .ns(ns_q), .dl(dl_q), .sl(sl_q), .ten(ten_q), .tdl(tdl_q), .tsl(tsl_q),
    .dtot(dtot), .stot(stot), .ctrl_len(ctrl_len), .user_len(user_len)
  );

  always_comb begin
    go        = start && (ph_q == PH_IDLE);
    in_ready  = (ph_q == PH_FILL);
    out_valid = (ph_q == PH_DRAIN);
    busy      = (ph_q != PH_IDLE);
    in_fire   = in_valid && in_ready;
    out_fire  = out_valid && out_ready;
    ecc_base  = dtot + stot;
    exp_in    = to_ctrl_q ? user_len : ctrl_len;
    out_len   = to_ctrl_q ? ctrl_len : user_len;
    wr_en     = in_fire && (in_cnt_q < exp_in);
    walk_step = to_ctrl_q ? out_fire : wr_en;
    wr_addr   = to_ctrl_q ? in_cnt_q : walk_addr;
    rd_addr   = to_ctrl_q ? walk_addr : out_cnt_q;
    pad_hit   = !to_ctrl_q && (out_cnt_q >= ecc_base) &&
                ((CNT_W'(out_cnt_q - ecc_base) & CNT_W'(ECC_SLOT - 1)) >= CNT_W'(ECC_LEN));
    out_byte  = pad_hit ? 8'hFF : rd_data;
    done      = done_q;
    len_err   = err_q;
  end

  bpr_walk #(.SECT_W(SECT_W), .LEN_W(LEN_W), .SPR_W(SPR_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .init(go), .step(walk_step),
    .ns(ns_q), .dl(dl_q), .sl(sl_q), .tdl(tdl_q), .tsl(tsl_q),
    .sbase(dtot), .ebase(ecc_base), .addr(walk_addr)
  );

  bpr_buf #(.DEPTH(BUF_DEPTH), .AW_IN(CNT_W)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(in_byte),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // Phase sequencing and counters
  always_comb begin
    ph_d      = ph_q;
    in_cnt_d  = in_cnt_q;
    out_cnt_d = out_cnt_q;
    done_d    = 1'b0;
    err_d     = err_q;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d      = PH_FILL;
          in_cnt_d  = '0;
          out_cnt_d = '0;
        end
      end
      PH_FILL: begin
        if (in_fire) begin
          in_cnt_d = in_cnt_q + CNT_W'(1);
          if (in_last) begin
            ph_d = PH_DRAIN;
            if (in_cnt_q != exp_in - CNT_W'(1)) err_d = 1'b1;
          end
        end
      end
      PH_DRAIN: begin
        if (out_fire) begin
          out_cnt_d = out_cnt_q + CNT_W'(1);
          if (out_cnt_q == out_len - CNT_W'(1)) begin
            ph_d   = PH_IDLE;
            done_d = 1'b1;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      in_cnt_q  <= in_cnt_d;
      out_cnt_q <= out_cnt_d;
      done_q    <= done_d;
      err_q     <= err_d;
    end
  end

  // Configuration capture, enabled by an accepted start only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_ctrl_q <= 1'b0;
      ns_q      <= '0;
      dl_q      <= '0;
      sl_q      <= '0;
      ten_q     <= 1'b0;
      tdl_q     <= '0;
      tsl_q     <= '0;
    end else if (go) begin
      to_ctrl_q <= cfg_to_ctrl;
      ns_q      <= cfg_sections;
      dl_q      <= cfg_data_len;
      sl_q      <= cfg_spare_len;
      ten_q     <= cfg_tail_en;
      tdl_q     <= cfg_tail_data_len;
      tsl_q     <= cfg_tail_spare_len;
    end
  end
endmodule

// File: rtl/bpr_chk.sv
module bpr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       done,
  input logic       len_err
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !out_valid));

  p_no_early_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err);
endmodule

bind bch_page_reorder bpr_chk u_chk (.*);

// File: tb/bch_page_reorder_test.sv
module bch_page_reorder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, cfg_to_ctrl, cfg_tail_en;
  logic [3:0]  cfg_sections;
  logic [11:0] cfg_data_len, cfg_tail_data_len;
  logic [7:0]  cfg_spare_len, cfg_tail_spare_len;
  logic        in_valid, in_ready, in_last, out_valid, out_ready;
  logic [7:0]  in_byte, out_byte;
  logic        done, len_err, busy;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [7:0] got_q[$];

  always #4 clk = ~clk;

  bch_page_reorder uut (.*);

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; start = 0; in_valid = 0; in_last = 0; in_byte = 0; out_ready = 0;
    cfg_to_ctrl = 0; cfg_sections = 0; cfg_data_len = 0; cfg_spare_len = 0;
    cfg_tail_en = 0; cfg_tail_data_len = 0; cfg_tail_spare_len = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_page(bit dir, int ns, int dl, int sl, bit ten, int tdl, int tsl,
                          int drop, bit scramble, bit exp_err, string tag);
    logic [7:0] ctrlq[$], udq[$], usq[$], effq[$], einq[$], inq[$], expq[$];
    logic [7:0] b;
    int k, mism, first, early, pads_bad, base, nt;
    for (int t = 0; t < ns + int'(ten); t++) begin
      int d = (t < ns) ? dl : tdl;
      int s = (t < ns) ? sl : tsl;
      for (int i = 0; i < d; i++) begin b = 8'($urandom); ctrlq.push_back(b); udq.push_back(b); end
      for (int i = 0; i < s; i++) begin b = 8'($urandom); ctrlq.push_back(b); usq.push_back(b); end
      for (int i = 0; i < 30; i++) begin
        b = 8'($urandom); ctrlq.push_back(b); effq.push_back(b); einq.push_back(b);
      end
      for (int i = 0; i < 2; i++) begin effq.push_back(8'hFF); einq.push_back(8'($urandom)); end
    end
    nt = ns + int'(ten);
    if (dir) begin inq = {udq, usq, einq}; expq = ctrlq; end
    else begin inq = ctrlq; expq = {udq, usq, effq}; end
    for (int i = 0; i < drop; i++) void'(inq.pop_back());

    @(negedge clk);
    cfg_to_ctrl = dir; cfg_sections = 4'(ns); cfg_data_len = 12'(dl); cfg_spare_len = 8'(sl);
    cfg_tail_en = ten; cfg_tail_data_len = 12'(tdl); cfg_tail_spare_len = 8'(tsl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin
      cfg_to_ctrl = ~dir; cfg_sections = 4'(ns + 1); cfg_data_len = 12'(dl + 7);
      cfg_spare_len = 8'(sl + 3); cfg_tail_en = ~ten; cfg_tail_data_len = 12'd9; cfg_tail_spare_len = 8'd4;
    end

    k = 0; early = 0;
    while (k < inq.size()) begin
      if (out_valid) early++;
      in_valid = ($urandom_range(3) != 0);
      in_byte = inq[k];
      in_last = (k == inq.size() - 1);
      if (in_valid && in_ready) k++;
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
    check(early == 0, "R8", "out_valid cycles during capture", early, 0);

    got_q.delete();
    while (got_q.size() < expq.size()) begin
      out_ready = ($urandom_range(2) != 0);
      if (out_valid && out_ready) got_q.push_back(out_byte);
      @(negedge clk);
    end
    out_ready = 0;
    check(done == 1'b1, "R9", "done after last byte", int'(done), 1);
    check(out_valid == 1'b0, "R9", "out_valid after page end", int'(out_valid), 0);
    @(negedge clk);
    check(done == 1'b0, "R9", "done width", int'(done), 0);
    check(len_err == exp_err, "R10", "len_err", int'(len_err), int'(exp_err));

    if (drop == 0) begin
      mism = 0; first = -1;
      for (int i = 0; i < expq.size(); i++)
        if (got_q[i] !== expq[i]) begin mism++; if (first < 0) first = i; end
      check(mism == 0, tag, $sformatf("byte mismatches (first at %0d)", first), mism, 0);
      if (!dir) begin
        pads_bad = 0;
        base = udq.size() + usq.size();
        for (int j = 0; j < nt; j++)
          for (int p = 30; p < 32; p++)
            if (got_q[base + 32*j + p] !== 8'hFF) pads_bad++;
        check(pads_bad == 0, "R4", "non-0xFF pad bytes", pads_bad, 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R1 reset state
    check(in_ready == 0, "R1", "in_ready", int'(in_ready), 0);
    check(out_valid == 0, "R1", "out_valid", int'(out_valid), 0);
    check(done == 0, "R1", "done", int'(done), 0);
    check(len_err == 0, "R1", "len_err", int'(len_err), 0);
    check(busy == 0, "R1", "busy", int'(busy), 0);

    run_page(0, 2, 512, 16, 0, 0, 0, 0, 0, 0, "R3");
    run_page(1, 2, 512, 16, 0, 0, 0, 0, 0, 0, "R5");
    run_page(0, 2, 512, 8, 1, 300, 5, 0, 0, 0, "R6");
    run_page(1, 2, 512, 8, 1, 300, 5, 0, 0, 0, "R6");
    run_page(0, 3, 512, 0, 1, 100, 0, 0, 0, 0, "R7");
    run_page(1, 3, 512, 0, 1, 100, 0, 0, 0, 0, "R7");
    run_page(1, 1, 2048, 24, 0, 0, 0, 0, 0, 0, "R11");
    run_page(0, 1, 2048, 24, 0, 0, 0, 0, 0, 0, "R11");
    run_page(0, 2, 520, 12, 1, 40, 3, 0, 1, 0, "R2");

    for (int r = 0; r < 3; r++) begin
      bit dir = 1'($urandom);
      run_page(dir, int'($urandom_range(2, 1)), int'($urandom_range(700, 512)),
               int'($urandom_range(40, 0)), 1'($urandom), int'($urandom_range(200, 1)),
               int'($urandom_range(20, 0)), 0, 0, 0, dir ? "R5" : "R3");
    end

    // R10 short page, then sticky across a good page, then cleared by reset
    run_page(0, 1, 512, 10, 0, 0, 0, 1, 0, 1, "R10");
    run_page(1, 1, 512, 10, 0, 0, 0, 0, 0, 1, "R10");
    do_reset();
    check(len_err == 0, "R10", "len_err after reset", int'(len_err), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule